// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block is the command side of a small serial EEPROM that holds 64 words of 16 bits. A host selects it with a chip-select line, clocks bits in on a serial clock and data-in line, and receives read data or a ready/busy flag on a data-out pin. The data-out pin is given as a value plus an output enable, so a pad can tri-state it. All three host inputs are synchronised into the system clock domain. Serial clock rising edges are found by edge detection.

Each transaction opens with a start bit, which is the first sampled one. Two opcode bits follow, then six address bits. Opcode 00 takes a sub-command from the two highest address bits. Read, write and write-all frames carry a further 16 data bits. Writes and erases are guarded by a write-enable latch. Each write or erase runs a self-timed program cycle whose length is a parameter. The cycle completes even if chip select falls. After a low-then-high pulse on chip select, the host can poll the cycle's progress on data out.

The storage is a single-write-port register array that block RAM can implement. Whole-array operations sweep the addresses during the program cycle.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is low, `so_en` is 0 within a few system clocks and any frame in progress is abandoned; a later frame restarts from the start bit.
- R2: With chip select high and no start bit yet, serial clocks that sample `di` low change nothing; the first rising edge that samples `di` high is the start bit.
- R3: After the start bit come opcode bits (first bit is the MSB) and then address bits A5..A0. Opcode 10 is read, 01 is write and 11 is erase. Opcode 00 is decoded on A5:A4: 00 is write disable, 01 is write all, 10 is erase all and 11 is write enable.
- R4: A read uses 25 rising edges. After edge 9, `so_en` is 1 and `so` is 0. After edges 10 to 25, `so` carries the stored word from bit 15 down to bit 0.
- R5: A write takes 16 data bits, MSB first, on edges 10 to 25, and stores them at the address.
- R6: Erase sets the addressed word to 16'hFFFF. Erase all sets every word to 16'hFFFF. Write all stores its data word at every address.
- R7: The write-enable latch is clear after reset. Write enable sets it and write disable clears it. While it is clear, write, erase, write all and erase all leave the array unchanged.
- R8: Once a frame has received all of its edges, further edges are ignored until chip select goes low, even if they form a valid command.
- R9: A program cycle lasts at least PROG_CYCLES system clocks and at least as many clocks as there are words. It completes even if chip select is low for the whole cycle, and `so_en` stays 0 while chip select is low.
- R10: After a write or erase has started, chip select going low and then high drives `so_en` to 1, with `so` = 0 while busy and `so` = 1 once ready. Without that chip-select pulse, `so_en` stays 0.
- R11: Write enable and write disable frames never drive `so`: `so_en` stays 0 from the start bit to the end of the frame.
- R12: While a program cycle is busy, no start bit is accepted and the status output is not disturbed by serial clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the host, active high, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| di | input | 1 | Serial data in, sampled on serial clock rising edges |
| so | output | 1 | Serial data out value (read data or ready flag) |
| so_en | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
The bench keeps the default word count and width, so the boundary addresses 0 and 63 and the sub-command decode on the top two address bits are exercised as they would be in use. It sets PROG_CYCLES to 96 rather than the default. With that value, the busy phase ends within a few serial clocks. This puts several things within reach: polling busy and then ready, having serial clocks rejected during a running cycle, and holding chip select low through a whole cycle, all at a short run length. Random write and read-back traffic from a fixed seed covers many address and data patterns against a word model kept in the bench.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE,
    CMD_ERASE,
    CMD_ERASE_ALL,
    CMD_WRITE_ALL,
    CMD_WR_ENABLE,
    CMD_WR_DISABLE
  } cmd_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SHIFT,
    FR_DONE
  } frame_e;

  // opcode first, then the top two address bits for the 00 group
  function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] sub);
    cmd_e c;
    case (op)
      2'b10:   c = CMD_READ;
      2'b01:   c = CMD_WRITE;
      2'b11:   c = CMD_ERASE;
      default: begin
        case (sub)
          2'b00:   c = CMD_WR_DISABLE;
          2'b01:   c = CMD_WRITE_ALL;
          2'b10:   c = CMD_ERASE_ALL;
          default: c = CMD_WR_ENABLE;
        endcase
      end
    endcase
    return c;
  endfunction

  function automatic logic has_data_phase(input cmd_e c);
    return (c == CMD_READ) || (c == CMD_WRITE) || (c == CMD_WRITE_ALL);
  endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/mw_frame.sv
module mw_frame import mw_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              rise,
  input  logic              di_s,
  input  logic              busy,
  output logic              start_seen,
  output logic              hdr_fire,
  output cmd_e              hdr_cmd,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              dph_rise,
  output logic              dat_fire,
  output logic [DATA_W-1:0] dat_word,
  output logic              idle
);

  localparam int HDR_BITS  = 2 + ADDR_W;
  localparam int SHORT_TOT = 1 + HDR_BITS;
  localparam int LONG_TOT  = SHORT_TOT + DATA_W;
  localparam int CNT_W     = $clog2(LONG_TOT + 1);

  frame_e              st;
  logic [CNT_W-1:0]    cnt;
  logic [HDR_BITS-1:0] hdr_sh;
  logic [DATA_W-1:0]   dat_sh;
  cmd_e                cmd_q;

  logic [HDR_BITS-1:0] hdr_next;
  logic [DATA_W-1:0]   dat_next;
  cmd_e                cmd_next;

  always_comb begin
    hdr_next = {hdr_sh[HDR_BITS-2:0], di_s};
    dat_next = {dat_sh[DATA_W-2:0], di_s};
    cmd_next = decode_cmd(hdr_next[HDR_BITS-1 -: 2], hdr_next[ADDR_W-1 -: 2]);
  end

  always_ff @(posedge clk) begin
    start_seen <= 1'b0;
    hdr_fire   <= 1'b0;
    dph_rise   <= 1'b0;
    dat_fire   <= 1'b0;
    if (rst || !cs_s) begin
      st     <= FR_IDLE;
      cnt    <= '0;
      cmd_q  <= CMD_NONE;
      hdr_sh <= '0;
      dat_sh <= '0;
    end else if (rise) begin
      case (st)
        FR_IDLE: begin
          if (di_s && !busy) begin
            st         <= FR_SHIFT;
            cnt        <= CNT_W'(1);
            start_seen <= 1'b1;
          end
        end
        FR_SHIFT: begin
          cnt <= cnt + 1'b1;
          if (cnt < CNT_W'(SHORT_TOT)) begin
            hdr_sh <= hdr_next;
            if (cnt == CNT_W'(SHORT_TOT - 1)) begin
              hdr_fire <= 1'b1;
              cmd_q    <= cmd_next;
              if (!has_data_phase(cmd_next)) st <= FR_DONE;
            end
          end else begin
            dat_sh   <= dat_next;
            dph_rise <= 1'b1;
            if (cnt == CNT_W'(LONG_TOT - 1)) begin
              dat_fire <= (cmd_q == CMD_WRITE) || (cmd_q == CMD_WRITE_ALL);
              st       <= FR_DONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign hdr_cmd  = cmd_q;
  assign hdr_addr = hdr_sh[ADDR_W-1:0];
  assign dat_word = dat_sh;
  assign idle     = (st == FR_IDLE);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(LONG_TOT));

  a_r3_single_fire: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_fire, dat_fire, start_seen}));

  a_r12_busy_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (cs_s && rise && st == FR_IDLE && di_s && busy) |=> (st == FR_IDLE));

  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (st == FR_DONE && cs_s) |=> (st == FR_DONE || !$past(cs_s) || !cs_s) && !hdr_fire);

endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mw_prog.sv
module mw_prog #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int RUN   = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH;
  localparam int CW    = $clog2(RUN + 1);

  logic [CW-1:0]     tick;
  logic              all_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tick   <= '0;
      all_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      tick   <= '0;
      all_q  <= all;
      addr_q <= addr;
      data_q <= data;
    end else if (busy) begin
      tick <= tick + 1'b1;
      if (tick == CW'(RUN - 1)) busy <= 1'b0;
    end
  end

  // sweep the addresses once; a single-word job writes only its own slot
  assign we    = busy && (tick < CW'(DEPTH)) && (all_q || tick[ADDR_W-1:0] == addr_q);
  assign waddr = tick[ADDR_W-1:0];
  assign wdata = data_q;

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  a_r9_runs_on: assert property (@(posedge clk) disable iff (rst)
    (busy && tick < CW'(DEPTH)) |=> busy);

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave import mw_pkg::*; #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic so,
  output logic so_en
);

  logic [2:0] pins_s;
  logic       cs_s, sclk_s, di_s;
  logic       sclk_d, cs_d, rise;

  mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({cs, sclk, di}),
    .sync_o  (pins_s)
  );

  assign {cs_s, sclk_s, di_s} = pins_s;
  assign rise = sclk_s && !sclk_d;

  logic              start_seen, hdr_fire, dph_rise, dat_fire, frame_idle;
  cmd_e              hdr_cmd;
  logic [ADDR_W-1:0] hdr_addr;
  logic [DATA_W-1:0] dat_word;
  logic              busy;

  mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
    .clk        (clk),
    .rst        (rst),
    .cs_s       (cs_s),
    .rise       (rise),
    .di_s       (di_s),
    .busy       (busy),
    .start_seen (start_seen),
    .hdr_fire   (hdr_fire),
    .hdr_cmd    (hdr_cmd),
    .hdr_addr   (hdr_addr),
    .dph_rise   (dph_rise),
    .dat_fire   (dat_fire),
    .dat_word   (dat_word),
    .idle       (frame_idle)
  );

  logic              wen_q;
  logic              prog_start, prog_all;
  logic [DATA_W-1:0] prog_data;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata, rd_data;

  always_comb begin
    prog_start = wen_q && (
                 (hdr_fire && (hdr_cmd == CMD_ERASE || hdr_cmd == CMD_ERASE_ALL)) ||
                 (dat_fire && (hdr_cmd == CMD_WRITE || hdr_cmd == CMD_WRITE_ALL)));
    prog_all   = (hdr_cmd == CMD_ERASE_ALL) || (hdr_cmd == CMD_WRITE_ALL);
    prog_data  = (hdr_cmd == CMD_ERASE || hdr_cmd == CMD_ERASE_ALL) ? '1 : dat_word;
  end

  mw_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) i_prog (
    .clk   (clk),
    .rst   (rst),
    .start (prog_start),
    .all   (prog_all),
    .addr  (hdr_addr),
    .data  (prog_data),
    .busy  (busy),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (hdr_addr),
    .rdata (rd_data)
  );

  logic              rd_mode, rd_load, rd_bit;
  logic [DATA_W-1:0] rd_sh;
  logic              armed, stat_en;
  logic              show_stat;

  assign show_stat = stat_en && frame_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b0;
      wen_q   <= 1'b0;
      rd_mode <= 1'b0;
      rd_load <= 1'b0;
      rd_bit  <= 1'b0;
      rd_sh   <= '0;
      armed   <= 1'b0;
      stat_en <= 1'b0;
      so      <= 1'b0;
      so_en   <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      cs_d    <= cs_s;
      rd_load <= hdr_fire && (hdr_cmd == CMD_READ);

      if (hdr_fire && hdr_cmd == CMD_WR_ENABLE)  wen_q <= 1'b1;
      if (hdr_fire && hdr_cmd == CMD_WR_DISABLE) wen_q <= 1'b0;

      if (prog_start)      armed <= 1'b1;
      else if (start_seen) armed <= 1'b0;

      if (!cs_s || start_seen)       stat_en <= 1'b0;
      else if (!cs_d && armed)       stat_en <= 1'b1;

      if (!cs_s) begin
        rd_mode <= 1'b0;
      end else if (hdr_fire && hdr_cmd == CMD_READ) begin
        rd_mode <= 1'b1;
        rd_bit  <= 1'b0;
      end

      if (rd_load) begin
        rd_sh <= rd_data;
      end else if (dph_rise && rd_mode) begin
        rd_bit <= rd_sh[DATA_W-1];
        rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
      end

      so_en <= cs_s && (rd_mode || show_stat);
      so    <= rd_mode ? rd_bit : (show_stat ? !busy : 1'b0);
    end
  end

  a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !so_en);

  a_r7_program_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wen_q));

  a_r11_enable_frames_silent: assert property (@(posedge clk) disable iff (rst)
    (hdr_fire && (hdr_cmd == CMD_WR_ENABLE || hdr_cmd == CMD_WR_DISABLE)) |=> !so_en);

  a_r4_read_drives_pin: assert property (@(posedge clk) disable iff (rst)
    (rd_load && cs_s) |=> so_en);

endmodule

// File: tb/test_mw_eeprom_slave.sv
`timescale 1ns/1ps
module test_mw_eeprom_slave;

  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int PC    = 96;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic so, so_en;

  always #2.5 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC), .SYNC_STAGES(2)) i_mw_eeprom_slave (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .so(so), .so_en(so_en)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [DEPTH];
  bit wen_m = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_up();
    cs = 1'b1; sys(6);
  endtask

  task automatic cs_down();
    cs = 1'b0; di = 1'b0; sys(6);
  endtask

  task automatic clk_bit(input logic b, output logic s, output logic e);
    di = b; sys(HALF);
    sclk = 1'b1; sys(HALF);
    s = so; e = so_en;
    sclk = 1'b0;
  endtask

  // start bit, opcode, address; returns OR of so_en over these edges and last sample
  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a,
                          output logic en_any, output logic s_last, output logic e_last);
    logic s, e;
    en_any = 1'b0;
    clk_bit(1'b1, s, e); en_any |= e;
    for (int i = 1; i >= 0; i--) begin clk_bit(op[i], s, e); en_any |= e; end
    for (int i = AW-1; i >= 0; i--) begin clk_bit(a[i], s, e); en_any |= e; end
    s_last = s; e_last = e;
  endtask

  function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
    return model[a];
  endfunction

  task automatic model_prog(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (!wen_m) return;
    case (kind)
      0: model[a] = d;
      1: model[a] = '1;
      2: for (int i = 0; i < DEPTH; i++) model[i] = d;
      default: for (int i = 0; i < DEPTH; i++) model[i] = '1;
    endcase
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int pre, output logic [DW-1:0] w, output logic dummy_ok);
    logic s, e, en_any;
    cs_up();
    for (int i = 0; i < pre; i++) clk_bit(1'b0, s, e);
    send_hdr(2'b10, a, en_any, s, e);
    dummy_ok = (e === 1'b1) && (s === 1'b0);
    for (int i = DW-1; i >= 0; i--) begin clk_bit(1'b0, s, e); w[i] = s; end
    cs_down();
  endtask

  task automatic do_long(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit drop);
    logic s, e, en_any;
    cs_up();
    send_hdr(op, a, en_any, s, e);
    for (int i = DW-1; i >= 0; i--) clk_bit(d[i], s, e);
    if (drop) cs_down();
  endtask

  task automatic do_short(input logic [1:0] op, input logic [AW-1:0] a, output logic en_any);
    logic s, e;
    cs_up();
    send_hdr(op, a, en_any, s, e);
    cs_down();
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a, input int pre);
    logic [DW-1:0] w; logic ok;
    do_read(a, pre, w, ok);
    check(req, {16'h0, w}, {16'h0, expect_word(a)}, $sformatf("read word @%0d", a));
  endtask

  initial begin
    logic [DW-1:0] w; logic ok, en_any, s, e, bad_en;
    void'($urandom(32'h5EED));
    sys(4); rst = 1'b0; sys(4);
    check("R1", {31'h0, so_en}, 32'h0, "so_en after reset");

    // R7/R11: enable, erase all, then disable
    do_short(2'b00, 6'b110000, en_any); wen_m = 1'b1;
    check("R11", {31'h0, en_any}, 32'h0, "so_en during write enable");
    do_short(2'b00, 6'b100000, en_any); model_prog(3, '0, '0); sys(PC + 20);
    read_check("R6", 6'd0, 0);
    read_check("R6", 6'd63, 0);
    read_check("R6", 6'd37, 0);
    do_short(2'b00, 6'b000000, en_any); wen_m = 1'b0;
    check("R11", {31'h0, en_any}, 32'h0, "so_en during write disable");
    do_long(2'b01, 6'd5, 16'h1234, 1'b1); model_prog(0, 6'd5, 16'h1234); sys(PC + 20);
    read_check("R7", 6'd5, 0);

    // R8: trailing bits forming a write enable after a disable frame are ignored
    cs_up();
    send_hdr(2'b00, 6'b000000, en_any, s, e);
    send_hdr(2'b00, 6'b110000, en_any, s, e);
    cs_down();
    do_long(2'b01, 6'd7, 16'hABCD, 1'b1); sys(PC + 20);
    read_check("R8", 6'd7, 0);

    do_short(2'b00, 6'b111111, en_any); wen_m = 1'b1;
    do_long(2'b01, 6'd7, 16'hABCD, 1'b1); model_prog(0, 6'd7, 16'hABCD); sys(PC + 20);
    do_read(6'd7, 0, w, ok);
    check("R4", {31'h0, ok}, 32'h1, "dummy zero after address");
    check("R5", {16'h0, w}, {16'h0, expect_word(6'd7)}, "written word");
    do_short(2'b11, 6'd7, en_any); model_prog(1, 6'd7, '0); sys(PC + 20);
    read_check("R6", 6'd7, 0);
    read_check("R3", 6'd8, 0);

    do_long(2'b00, 6'b010101, 16'h5A3C, 1'b1); model_prog(2, '0, 16'h5A3C); sys(PC + 20);
    read_check("R6", 6'd0, 0);
    read_check("R6", 6'd63, 0);
    read_check("R3", 6'd20, 0);

    // R10/R12: status polling around a running write
    do_long(2'b01, 6'd9, 16'h0F0F, 1'b0); model_prog(0, 6'd9, 16'h0F0F);
    sys(4);
    check("R10", {31'h0, so_en}, 32'h0, "no status without chip select pulse");
    cs_down(); cs_up();
    check("R10", {30'h0, so_en, so}, 32'h2, "busy status");
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s, e);
    check("R12", {30'h0, so_en, so}, 32'h2, "status kept while busy");
    cs_down(); sys(PC); cs_up();
    check("R10", {30'h0, so_en, so}, 32'h3, "ready status");
    cs_down();
    read_check("R5", 6'd9, 0);

    // R9: chip select low through the whole cycle
    do_long(2'b01, 6'd11, 16'h7777, 1'b1); model_prog(0, 6'd11, 16'h7777);
    bad_en = 1'b0;
    for (int i = 0; i < (PC + 20) / 10; i++) begin sys(10); bad_en |= so_en; end
    check("R9", {31'h0, bad_en}, 32'h0, "so_en while deselected during program");
    cs_up();
    check("R10", {30'h0, so_en, so}, 32'h3, "ready after deselected cycle");
    cs_down();
    read_check("R9", 6'd11, 0);

    // R2: leading zero clocks before the start bit
    read_check("R2", 6'd11, 5);

    // R1: abort a read mid-frame
    cs_up();
    send_hdr(2'b10, 6'd9, en_any, s, e);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s, e);
    check("R4", {31'h0, e}, 32'h1, "so_en during read data");
    cs_down();
    check("R1", {31'h0, so_en}, 32'h0, "so_en after deselect");
    read_check("R1", 6'd9, 0);

    // random traffic
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] a; logic [DW-1:0] d;
      a = AW'($urandom % DEPTH); d = DW'($urandom);
      do_long(2'b01, a, d, 1'b1); model_prog(0, a, d); sys(PC + 20);
      read_check("R5", a, 0);
      read_check("R5", AW'($urandom % DEPTH), 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule